// File: doc/BRIEF.md
# Register Stack-Hint Tracker

The tracker keeps one prediction bit per architectural register that says whether an address formed from that register is likely to land in the stack. The bits follow values as they move through the datapath. A load result carries no hint. An ALU result inherits the hint of either of its operands. After a memory access, the base register's bit is corrected with the access's resolved stack classification.

On every memory access the block gives a same-cycle prediction of which cache to try first. One cycle later it gives the resolved classification and a retry flag that is raised when the prediction was wrong. The two fixed frame registers (stack pointer and frame pointer) are always treated as stack. Other bases are resolved by one of two methods. The first is a single-ended check of the address against the stack pointer less a red-zone allowance. The second compares the hit results of the data TLB and a separate stack TLB, and uses the range check when the TLBs do not decide the case. Under the TLB method, a stack-TLB miss on a frame-register access is reported as a fill fault.

Top module: `stack_hint_tracker`

## Requirements
- R1: After reset every hint bit is 0 and `res_valid` is 0.
- R2: `acc_pred` is a combinational function of `acc_base` and the stored hints, whatever the value of `acc_valid`. It is 1 when the base is register 1 or register 2. Otherwise it is the base's hint bit, and for register 0 that bit is always 0.
- R3: A retiring write with `wr_kind` = 0 (load) clears the destination's hint bit from the next cycle on.
- R4: A retiring write with `wr_kind` = 1 (ALU) sets the destination's bit to the OR of the bits of `wr_rs1` and `wr_rs2`. When another event writes a source bit in the same cycle, the OR uses the old value.
- R5: Writes aimed at register 0, from either port, leave its hint at 0.
- R6: An access with `acc_valid` = 1 sets the base register's bit to the resolved classification on the next cycle. If the retire port writes the same register in the same cycle, the retire port wins.
- R7: An access based on register 1 or register 2 is always classified as stack.
- R8: With `acc_mode` = 0 (range), a base other than register 1 or 2 is stack exactly when `acc_addr` + 2092 > `acc_sp`. The sum is computed one bit wider than the address, so it never wraps.
- R9: With `acc_mode` = 1 (TLB) and a base other than register 1 or 2, the result is taken from the TLBs when they disagree. A stack-TLB hit with a data-TLB miss gives stack. A data-TLB hit with a stack-TLB miss gives non-stack. When both hit or both miss, the R8 range check decides.
- R10: `res_fault` is 1 only for a TLB-mode access based on register 1 or 2 whose stack TLB missed.
- R11: All `res_*` outputs are registered and refer to the access of the previous cycle. `res_valid` follows `acc_valid`. `res_retry` is 1 when `res_stack` differs from the `acc_pred` shown for that access.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | A register write retires this cycle |
| wr_kind | input | 1 | 0 = load result, 1 = ALU result |
| wr_rd | input | 5 | Destination register |
| wr_rs1 | input | 5 | First ALU source register |
| wr_rs2 | input | 5 | Second ALU source register |
| acc_valid | input | 1 | A memory access is presented |
| acc_base | input | 5 | Base register of the access |
| acc_addr | input | 32 | Effective address |
| acc_sp | input | 32 | Current stack-pointer value |
| acc_mode | input | 1 | 0 = range check, 1 = TLB comparison |
| dtlb_hit | input | 1 | Data TLB hit for this access |
| stlb_hit | input | 1 | Stack TLB hit for this access |
| acc_pred | output | 1 | Predicted stack access (probe stack cache first) |
| res_valid | output | 1 | Resolved result is present |
| res_stack | output | 1 | Resolved classification: stack |
| res_fault | output | 1 | Stack-TLB fill fault on a frame-register access |
| res_retry | output | 1 | Prediction was wrong; probe the other cache |

## Verification
The assertions assume that the control inputs are never unknown while reset is released. They also assume that a register index on the retire port refers to one of the 32 registers. The retry property relies on `acc_pred` being sampled in the same cycle as the access, so it takes `acc_base` to be stable across the clock edge. The stimulus keeps to these assumptions: it drives every input once per cycle at the falling edge and draws indices modulo 32. Addresses are clustered around the red-zone limit so that both sides of the range check occur often, and the TLB hit bits are drawn independently so that all four hit/miss combinations come up.

// File: rtl/sht_pkg.sv
package sht_pkg;

    // Kind of retiring register write.
    typedef enum logic {
        WR_LOAD = 1'b0,
        WR_ALU  = 1'b1
    } wr_kind_e;

    // How a non-frame access is classified.
    typedef enum logic {
        MODE_RANGE = 1'b0,
        MODE_TLB   = 1'b1
    } cls_mode_e;

    // Registered per-access result.
    typedef struct packed {
        logic valid;
        logic stack;
        logic fault;
        logic retry;
    } result_t;

endpackage

// File: rtl/sht_classify.sv
// Resolves whether one memory access targets the stack.
module sht_classify
    import sht_pkg::*;
#(
    parameter int XLEN     = 32,
    parameter int RIDX_W   = 5,
    parameter int RED_ZONE = 2092,
    parameter int SP_IDX   = 1,
    parameter int FP_IDX   = 2
) (
    input  logic [RIDX_W-1:0] base,
    input  logic [XLEN-1:0]   addr,
    input  logic [XLEN-1:0]   sp,
    input  logic              mode,
    input  logic              dtlb_hit,
    input  logic              stlb_hit,
    output logic              is_frame,
    output logic              stack,
    output logic              fault
);

    localparam logic [XLEN:0]     RED_EXT = (XLEN+1)'(RED_ZONE);
    localparam logic [RIDX_W-1:0] SP_SEL  = RIDX_W'(SP_IDX);
    localparam logic [RIDX_W-1:0] FP_SEL  = RIDX_W'(FP_IDX);

    logic [XLEN:0] addr_plus_red;
    logic          in_window;
    logic          tlb_says_stack;
    logic          tlb_says_heap;
    cls_mode_e     mode_e;

    assign mode_e = cls_mode_e'(mode);

    // addr > sp - RED_ZONE, evaluated without wrap-around.
    always_comb begin
        addr_plus_red = {1'b0, addr} + RED_EXT;
        in_window     = (addr_plus_red > {1'b0, sp});
    end

    always_comb begin
        is_frame       = (base == SP_SEL) || (base == FP_SEL);
        tlb_says_stack = !dtlb_hit &&  stlb_hit;
        tlb_says_heap  =  dtlb_hit && !stlb_hit;
        stack          = in_window;
        fault          = 1'b0;
        if (is_frame) begin
            stack = 1'b1;
            fault = (mode_e == MODE_TLB) && !stlb_hit;
        end else if (mode_e == MODE_TLB) begin
            if (tlb_says_stack) begin
                stack = 1'b1;
            end else if (tlb_says_heap) begin
                stack = 1'b0;
            end
        end
    end

endmodule

// File: rtl/sht_hint_file.sv
// One hint bit per register, updated by retiring writes and access results.
module sht_hint_file
    import sht_pkg::*;
#(
    parameter int NREG   = 32,
    parameter int RIDX_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic              wr_kind,
    input  logic [RIDX_W-1:0] wr_rd,
    input  logic [RIDX_W-1:0] wr_rs1,
    input  logic [RIDX_W-1:0] wr_rs2,
    input  logic              upd_valid,
    input  logic [RIDX_W-1:0] upd_idx,
    input  logic              upd_val,
    output logic [NREG-1:0]   hints
);

    logic [NREG-1:0] hint_d;
    logic [NREG-1:0] hint_q;
    logic            alu_val;
    logic            wr_val;
    wr_kind_e        kind_e;

    assign kind_e = wr_kind_e'(wr_kind);

    // Sources are read from the registered state: same-cycle updates are not seen.
    always_comb begin
        alu_val = hint_q[wr_rs1] | hint_q[wr_rs2];
        wr_val  = (kind_e == WR_ALU) ? alu_val : 1'b0;
    end

    for (genvar g = 0; g < NREG; g++) begin : g_bit
        if (g == 0) begin : g_zero
            always_comb hint_d[g] = 1'b0;
        end else begin : g_live
            always_comb begin
                hint_d[g] = hint_q[g];
                if (upd_valid && (upd_idx == RIDX_W'(g))) begin
                    hint_d[g] = upd_val;
                end
                // Retire port has priority over the access update.
                if (wr_valid && (wr_rd == RIDX_W'(g))) begin
                    hint_d[g] = wr_val;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hint_q <= '0;
        end else begin
            hint_q <= hint_d;
        end
    end

    assign hints = hint_q;

endmodule

// File: rtl/stack_hint_tracker.sv
// Top: prediction, classification and registered per-access result.
module stack_hint_tracker
    import sht_pkg::*;
#(
    parameter int NREG     = 32,
    parameter int XLEN     = 32,
    parameter int RED_ZONE = 2092,
    parameter int SP_IDX   = 1,
    parameter int FP_IDX   = 2,
    localparam int RIDX_W  = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic              wr_kind,
    input  logic [RIDX_W-1:0] wr_rd,
    input  logic [RIDX_W-1:0] wr_rs1,
    input  logic [RIDX_W-1:0] wr_rs2,
    input  logic              acc_valid,
    input  logic [RIDX_W-1:0] acc_base,
    input  logic [XLEN-1:0]   acc_addr,
    input  logic [XLEN-1:0]   acc_sp,
    input  logic              acc_mode,
    input  logic              dtlb_hit,
    input  logic              stlb_hit,
    output logic              acc_pred,
    output logic              res_valid,
    output logic              res_stack,
    output logic              res_fault,
    output logic              res_retry
);

    typedef struct packed {
        result_t res;
    } trk_state_t;

    trk_state_t      st_d;
    trk_state_t      st_q;
    logic [NREG-1:0] hint_vec;
    logic            cls_frame;
    logic            cls_stack;
    logic            cls_fault;

    sht_hint_file #(
        .NREG   (NREG),
        .RIDX_W (RIDX_W)
    ) u_hints (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_valid  (wr_valid),
        .wr_kind   (wr_kind),
        .wr_rd     (wr_rd),
        .wr_rs1    (wr_rs1),
        .wr_rs2    (wr_rs2),
        .upd_valid (acc_valid),
        .upd_idx   (acc_base),
        .upd_val   (cls_stack),
        .hints     (hint_vec)
    );

    sht_classify #(
        .XLEN     (XLEN),
        .RIDX_W   (RIDX_W),
        .RED_ZONE (RED_ZONE),
        .SP_IDX   (SP_IDX),
        .FP_IDX   (FP_IDX)
    ) u_classify (
        .base     (acc_base),
        .addr     (acc_addr),
        .sp       (acc_sp),
        .mode     (acc_mode),
        .dtlb_hit (dtlb_hit),
        .stlb_hit (stlb_hit),
        .is_frame (cls_frame),
        .stack    (cls_stack),
        .fault    (cls_fault)
    );

    // Frame registers always predict stack; others use their stored bit.
    assign acc_pred = cls_frame | hint_vec[acc_base];

    always_comb begin
        st_d = st_q;
        st_d.res.valid = acc_valid;
        st_d.res.stack = acc_valid & cls_stack;
        st_d.res.fault = acc_valid & cls_fault;
        st_d.res.retry = acc_valid & (cls_stack ^ acc_pred);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign res_valid = st_q.res.valid;
    assign res_stack = st_q.res.stack;
    assign res_fault = st_q.res.fault;
    assign res_retry = st_q.res.retry;

endmodule

// File: rtl/sht_checker.sv
// Temporal properties of the tracker, attached by bind.
module sht_checker #(
    parameter int NREG   = 32,
    parameter int RIDX_W = 5,
    parameter int SP_IDX = 1,
    parameter int FP_IDX = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_valid,
    input logic              wr_kind,
    input logic [RIDX_W-1:0] wr_rd,
    input logic [RIDX_W-1:0] wr_rs1,
    input logic [RIDX_W-1:0] wr_rs2,
    input logic              acc_valid,
    input logic [RIDX_W-1:0] acc_base,
    input logic              acc_mode,
    input logic              acc_pred,
    input logic              res_valid,
    input logic              res_stack,
    input logic              res_fault,
    input logic              res_retry,
    input logic [NREG-1:0]   hint_vec
);

    logic frame_base;
    assign frame_base = (acc_base == RIDX_W'(SP_IDX)) || (acc_base == RIDX_W'(FP_IDX));

    p_zero_pred_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_base == '0) |-> !acc_pred);

    p_frame_pred_r2: assert property (@(posedge clk) disable iff (!rst_n)
        frame_base |-> acc_pred);

    p_load_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_kind && (wr_rd != '0)) |=> !hint_vec[$past(wr_rd)]);

    p_alu_or_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_kind && (wr_rd != '0)) |=>
        (hint_vec[$past(wr_rd)] == ($past(hint_vec[wr_rs1]) | $past(hint_vec[wr_rs2]))));

    p_frame_stack_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && frame_base) |=> res_stack);

    p_fault_src_r10: assert property (@(posedge clk) disable iff (!rst_n)
        res_fault |-> ($past(frame_base) && $past(acc_mode) && res_valid));

    p_valid_follow_r11: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |=> res_valid);

    p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |=> !res_valid);

    p_retry_r11: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (res_retry == (res_stack != $past(acc_pred))));

endmodule

bind stack_hint_tracker sht_checker #(
    .NREG   (NREG),
    .RIDX_W (RIDX_W),
    .SP_IDX (SP_IDX),
    .FP_IDX (FP_IDX)
) u_sht_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_valid  (wr_valid),
    .wr_kind   (wr_kind),
    .wr_rd     (wr_rd),
    .wr_rs1    (wr_rs1),
    .wr_rs2    (wr_rs2),
    .acc_valid (acc_valid),
    .acc_base  (acc_base),
    .acc_mode  (acc_mode),
    .acc_pred  (acc_pred),
    .res_valid (res_valid),
    .res_stack (res_stack),
    .res_fault (res_fault),
    .res_retry (res_retry),
    .hint_vec  (hint_vec)
);

// File: tb/stack_hint_tracker_test.sv
module stack_hint_tracker_test;

    localparam int CLK_PERIOD = 10;
    localparam int NRAND      = 3000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_valid = 1'b0, wr_kind = 1'b0;
    logic [4:0]  wr_rd = '0, wr_rs1 = '0, wr_rs2 = '0;
    logic        acc_valid = 1'b0, acc_mode = 1'b0, dtlb_hit = 1'b0, stlb_hit = 1'b0;
    logic [4:0]  acc_base = '0;
    logic [31:0] acc_addr = '0, acc_sp = '0;
    logic        acc_pred, res_valid, res_stack, res_fault, res_retry;

    int checks = 0;
    int fails  = 0;

    // Bench model state
    bit mh [32];
    bit e_valid = 0, e_stack = 0, e_fault = 0, e_retry = 0;
    string e_tag = "R11";

    always #(CLK_PERIOD/2) clk = ~clk;

    stack_hint_tracker uut (
        .clk(clk), .rst_n(rst_n),
        .wr_valid(wr_valid), .wr_kind(wr_kind), .wr_rd(wr_rd),
        .wr_rs1(wr_rs1), .wr_rs2(wr_rs2),
        .acc_valid(acc_valid), .acc_base(acc_base), .acc_addr(acc_addr),
        .acc_sp(acc_sp), .acc_mode(acc_mode), .dtlb_hit(dtlb_hit), .stlb_hit(stlb_hit),
        .acc_pred(acc_pred), .res_valid(res_valid), .res_stack(res_stack),
        .res_fault(res_fault), .res_retry(res_retry)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic bit is_frame(input logic [4:0] b);
        return (b == 5'd1) || (b == 5'd2);
    endfunction

    // Returns {stack, fault}
    function automatic logic [1:0] classify(input logic [4:0] b, input logic [31:0] a,
                                            input logic [31:0] s, input bit m,
                                            input bit dh, input bit sh);
        logic [32:0] sum;
        bit rng;
        sum = {1'b0, a} + 33'd2092;
        rng = sum > {1'b0, s};
        if (is_frame(b)) return {1'b1, m && !sh};
        if (m && !dh && sh) return 2'b10;
        if (m && dh && !sh) return 2'b00;
        return {rng, 1'b0};
    endfunction

    task automatic step(input bit wv, input bit wk, input logic [4:0] rd,
                        input logic [4:0] r1, input logic [4:0] r2,
                        input bit av, input logic [4:0] b, input logic [31:0] a,
                        input logic [31:0] s, input bit m, input bit dh, input bit sh);
        bit pred;
        bit nh [32];
        logic [1:0] c;
        @(negedge clk);
        check(res_valid == e_valid, "R11", "res_valid", 32'(res_valid), 32'(e_valid));
        if (e_valid) begin
            check(res_stack == e_stack, e_tag, "res_stack", 32'(res_stack), 32'(e_stack));
            check(res_fault == e_fault, "R10", "res_fault", 32'(res_fault), 32'(e_fault));
            check(res_retry == e_retry, "R11", "res_retry", 32'(res_retry), 32'(e_retry));
        end
        wr_valid = wv; wr_kind = wk; wr_rd = rd; wr_rs1 = r1; wr_rs2 = r2;
        acc_valid = av; acc_base = b; acc_addr = a; acc_sp = s;
        acc_mode = m; dtlb_hit = dh; stlb_hit = sh;
        #1;
        pred = is_frame(b) ? 1'b1 : mh[b];
        check(acc_pred == pred, "R2", "acc_pred", 32'(acc_pred), 32'(pred));
        c = classify(b, a, s, m, dh, sh);
        e_valid = av;
        e_stack = c[1];
        e_fault = c[0];
        e_retry = c[1] ^ pred;
        e_tag   = is_frame(b) ? "R7" : (m ? "R9" : "R8");
        nh = mh;
        if (av && b != 0) nh[b] = c[1];
        if (wv && rd != 0) nh[rd] = wk ? (mh[r1] | mh[r2]) : 1'b0;
        mh = nh;
    endtask

    task automatic idle_peek(input logic [4:0] b, input bit expv, input string tag);
        step(0, 0, 0, 0, 0, 0, b, 0, 0, 0, 0, 0);
        check(acc_pred == expv, tag, "hint via acc_pred", 32'(acc_pred), 32'(expv));
    endtask

    localparam logic [31:0] SP0 = 32'h0001_0000;
    localparam logic [31:0] LIM = SP0 - 32'd2092;

    initial begin
        void'($urandom(32'h5EED_C0DE));
        foreach (mh[i]) mh[i] = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        check(res_valid == 1'b0, "R1", "res_valid after reset", 32'(res_valid), 0);
        for (int i = 0; i < 32; i++) begin
            idle_peek(5'(i), is_frame(5'(i)), is_frame(5'(i)) ? "R2" : "R1");
        end
        // R8 boundary: one above the limit is stack, the limit itself is not
        step(0, 0, 0, 0, 0, 1, 5'd5, LIM + 1, SP0, 0, 0, 0);
        idle_peek(5'd5, 1'b1, "R6");
        step(0, 0, 0, 0, 0, 1, 5'd6, LIM, SP0, 0, 0, 0);
        idle_peek(5'd6, 1'b0, "R8");
        // R4 OR, then R3 clear
        step(1, 1, 5'd7, 5'd5, 5'd6, 0, 0, 0, 0, 0, 0, 0);
        idle_peek(5'd7, 1'b1, "R4");
        step(1, 0, 5'd7, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        idle_peek(5'd7, 1'b0, "R3");
        // R4 read-old: access sets r8 while ALU reads r8
        step(1, 1, 5'd9, 5'd8, 5'd0, 1, 5'd8, SP0, SP0, 0, 0, 0);
        idle_peek(5'd9, 1'b0, "R4");
        idle_peek(5'd8, 1'b1, "R6");
        // R6 priority: load wins over access update on same register
        step(1, 0, 5'd10, 0, 0, 1, 5'd10, SP0, SP0, 0, 0, 0);
        idle_peek(5'd10, 1'b0, "R6");
        // R5: register 0 stays zero
        step(1, 1, 5'd0, 5'd5, 5'd8, 0, 0, 0, 0, 0, 0, 0);
        idle_peek(5'd0, 1'b0, "R5");
        step(0, 0, 0, 0, 0, 1, 5'd0, SP0, SP0, 0, 0, 0);
        idle_peek(5'd0, 1'b0, "R5");
        // R8 no wrap with small stack pointer
        step(0, 0, 0, 0, 0, 1, 5'd11, 32'd0, 32'd100, 0, 0, 0);
        idle_peek(5'd11, 1'b1, "R8");
        // R9 TLB decisions
        step(0, 0, 0, 0, 0, 1, 5'd12, 32'd0, SP0, 1, 0, 1);
        idle_peek(5'd12, 1'b1, "R9");
        step(0, 0, 0, 0, 0, 1, 5'd12, SP0, SP0, 1, 1, 0);
        idle_peek(5'd12, 1'b0, "R9");
        // R10 fault on frame register with stack TLB miss
        step(0, 0, 0, 0, 0, 1, 5'd1, 32'd0, SP0, 1, 1, 0);
        step(0, 0, 0, 0, 0, 1, 5'd2, 32'd0, SP0, 1, 0, 1);
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        // Constrained random mix
        for (int n = 0; n < NRAND; n++) begin
            logic [31:0] sp, ad;
            sp = ($urandom % 8 == 0) ? ($urandom % 4000) : $urandom;
            ad = ($urandom % 2 == 0) ? (sp - 32'd2092 + ($urandom % 17) - 32'd8) : $urandom;
            step(($urandom % 3) != 0, $urandom % 2, 5'($urandom % 32), 5'($urandom % 32),
                 5'($urandom % 32), ($urandom % 4) != 0, 5'($urandom % 32), ad, sp,
                 $urandom % 2, $urandom % 2, $urandom % 2);
        end
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL R11 watchdog actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule